// File: doc/BRIEF.md
# Authenticated-Cipher Phase Sequencer

This block is the controller that walks a lightweight, stream-style authenticated-encryption state-update core through one complete message. After a start request it runs the key/IV loading phase for a fixed number of steps. It then absorbs the associated-data words and encrypts the plaintext words, and each of these two phases closes with a fixed tail of padding steps. Last comes finalization, and the tag is read from the final keystream words of that phase. The state-update equations stay outside. The sequencer tells the core when to take a step (`step`) and which message word it sees (`msg_word`, chosen by `msg_sel`). It takes the core's keystream word back on `ks_word`.

The datapath width `DW` sets the step counts. Each cycle stands for `DW` single-bit steps, so the phases take 1792/DW, 256/DW (tail) and 768/DW cycles. With DW=32 these are 56, 8 and 24 cycles, and with DW=8 they are 224, 32 and 96 cycles. The tag is 128/DW words long. Associated data and plaintext arrive through valid/ready handshakes. A cycle without a valid word stalls both the step counter and the core, so the words do not have to arrive in consecutive cycles. Lengths are given in bits and are expected to be whole multiples of `DW`.

Top module: `aead_phase_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `phase` is 0 (idle) and `done`, `step`, `key_iv_load`, `ad_ready`, `pt_ready`, `ct_valid` and `tag_valid` are all low.
- R2: A `start` seen in idle opens the key/IV phase (`phase`=1) on the next cycle. That phase lasts exactly 1792/DW cycles, with `key_iv_load` and `step` high and `msg_sel`=2 (zero) in every one of them.
- R3: The associated-data phase (`phase`=2) first holds `ad_ready` high until ad_len/DW words have been taken. In those cycles `msg_sel`=0 (data), `msg_word` equals `ad_data`, and `step` equals `ad_valid`. A cycle with `ad_valid` low advances nothing.
- R4: After the associated-data words, exactly 256/DW tail cycles follow, and they also run when ad_len is 0. In the tail `ad_ready` is low and `step` is high. The first tail cycle has `msg_sel`=1 (pad) and `msg_word`=1. The others have `msg_sel`=2 and `msg_word`=0.
- R5: The encryption phase (`phase`=3) holds `pt_ready` high until pt_len/DW words have been taken. `ct_valid` equals `pt_valid` there, and `ct_word` equals `pt_data` XOR `ks_word` in the same cycle. When pt_len is 0, `ct_valid` never rises.
- R6: After the plaintext words, exactly 256/DW tail cycles follow with the same pad/zero pattern as R4. During the tail `pt_ready` and `ct_valid` stay low.
- R7: Finalization (`phase`=4) lasts exactly 768/DW cycles. `step` is high and `msg_sel`=2, `msg_word`=0 throughout.
- R8: `tag_valid` is high only in the last 128/DW cycles of finalization. `tag_idx` counts 0,1,… across those cycles, and `tag_word` equals `ks_word`.
- R9: `done` is high for one cycle, the one right after the last tag word. In that cycle `phase` is already 0, and a `start` given then begins a new run at once. A `start` given while a run is in progress has no effect on that run.
- R10: The phases always follow the order idle, key/IV, associated data, encryption, finalization, idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a run (taken in idle only) |
| ad_len | input | LEN_W | Associated-data length in bits |
| pt_len | input | LEN_W | Plaintext length in bits |
| ad_valid | input | 1 | Associated-data word offered |
| ad_data | input | DW | Associated-data word |
| ad_ready | output | 1 | Sequencer accepts associated-data words |
| pt_valid | input | 1 | Plaintext word offered |
| pt_data | input | DW | Plaintext word |
| pt_ready | output | 1 | Sequencer accepts plaintext words |
| ks_word | input | DW | Keystream word from the core, this cycle |
| phase | output | 3 | 0 idle, 1 key/IV, 2 assoc. data, 3 encrypt, 4 finalize |
| step | output | 1 | Core performs one state update this cycle |
| key_iv_load | output | 1 | Core absorbs key/IV material this cycle |
| msg_sel | output | 2 | Message source: 0 data, 1 pad, 2 zero |
| msg_word | output | DW | Message word presented to the core |
| ct_valid | output | 1 | Ciphertext word valid |
| ct_word | output | DW | Ciphertext word |
| tag_valid | output | 1 | Tag word valid |
| tag_idx | output | TAG_IW | Index of the tag word |
| tag_word | output | DW | Tag word |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can fall in the same cycle: the `done` pulse of one run and the `start` of the next. The bench provokes this by raising `start` in exactly that cycle on several runs of its sweep. It then expects the key/IV phase in the following cycle, with `done` already low and the full 1792/DW cycle count intact. A second overlap is a stalled handshake that meets a `start` held high through the data phase. The bench judges it by demanding unchanged phase lengths and word-for-word data/ciphertext alignment over every combination of zero to three words per phase, with and without stalls.

// File: rtl/aead_seq_pkg.sv
// Shared encodings for the authenticated-cipher phase sequencer.
// Assumes: phase and message-select codes are decoded by neighbouring logic,
// so their numeric values are fixed here and nowhere else.
package aead_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_INIT = 3'd1,
        PH_AD   = 3'd2,
        PH_ENC  = 3'd3,
        PH_FIN  = 3'd4
    } phase_e;

    typedef enum logic [1:0] {
        MS_DATA = 2'd0,
        MS_PAD  = 2'd1,
        MS_ZERO = 2'd2
    } msel_e;

    // Single-bit step counts of the algorithm, scaled per datapath width.
    localparam int unsigned INIT_BITS = 1792;
    localparam int unsigned TAIL_BITS = 256;
    localparam int unsigned FIN_BITS  = 768;
    localparam int unsigned TAG_BITS  = 128;

endpackage

// File: rtl/aead_word_tracker.sv
// Remaining-word counter for one data phase.
// Loaded with a word count when a run starts; decremented once per accepted
// word; 'pending' is high while words are still owed. Assumes load and take
// are never high together.
module aead_word_tracker #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_words,
    input  logic          take,
    output logic          pending
);

    logic [CW-1:0] left_q;

    // Hold, load or count down the number of outstanding words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= load_words;
        end else if (take && (left_q != '0)) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign pending = (left_q != '0);

endmodule

// File: rtl/aead_step_timer.sv
// Step counter for the fixed-length parts of each phase.
// Cleared on every phase change, advanced only on fixed-length steps.
// Assumes CW is wide enough for the longest phase.
module aead_step_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          adv,
    output logic [CW-1:0] cnt
);

    // Count fixed steps; restart at each phase boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/aead_msg_path.sv
// Message-word selection and ciphertext formation.
// Purely combinational: picks the data, pad or zero word for the core and
// XORs plaintext with the keystream of the same cycle.
module aead_msg_path
    import aead_seq_pkg::*;
#(
    parameter int DW = 32
) (
    input  msel_e         sel,
    input  logic          use_pt,
    input  logic [DW-1:0] ad_data,
    input  logic [DW-1:0] pt_data,
    input  logic [DW-1:0] ks_word,
    output logic [DW-1:0] msg_word,
    output logic [DW-1:0] ct_word
);

    localparam logic [DW-1:0] PAD_WORD = DW'(1);

    // Route the selected source onto the core's message input.
    always_comb begin
        case (sel)
            MS_DATA: msg_word = use_pt ? pt_data : ad_data;
            MS_PAD:  msg_word = PAD_WORD;
            default: msg_word = '0;
        endcase
    end

    assign ct_word = pt_data ^ ks_word;

endmodule

// File: rtl/aead_phase_seq.sv
// Phase sequencer for a stream-style authenticated-encryption core.
// Runs key/IV load, associated data, encryption and finalization in order.
// Data phases take words by valid/ready and stall on missing words; each
// data phase ends with a fixed pad/zero tail; the tag is the last words of
// finalization. Assumes lengths are whole multiples of DW and that DW
// divides 128.
module aead_phase_seq
    import aead_seq_pkg::*;
#(
    parameter int DW    = 32,
    parameter int LEN_W = 16,
    localparam int TAG_WORDS = TAG_BITS / DW,
    localparam int TAG_IW    = (TAG_WORDS > 1) ? $clog2(TAG_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  ad_len,
    input  logic [LEN_W-1:0]  pt_len,
    input  logic              ad_valid,
    input  logic [DW-1:0]     ad_data,
    output logic              ad_ready,
    input  logic              pt_valid,
    input  logic [DW-1:0]     pt_data,
    output logic              pt_ready,
    input  logic [DW-1:0]     ks_word,
    output logic [2:0]        phase,
    output logic              step,
    output logic              key_iv_load,
    output logic [1:0]        msg_sel,
    output logic [DW-1:0]     msg_word,
    output logic              ct_valid,
    output logic [DW-1:0]     ct_word,
    output logic              tag_valid,
    output logic [TAG_IW-1:0] tag_idx,
    output logic [DW-1:0]     tag_word,
    output logic              done
);

    localparam int DW_LG     = $clog2(DW);
    localparam int INIT_CYC  = INIT_BITS / DW;
    localparam int TAIL_CYC  = TAIL_BITS / DW;
    localparam int FIN_CYC   = FIN_BITS / DW;
    localparam int TAG_FIRST = FIN_CYC - TAG_WORDS;
    localparam int CNT_W     = $clog2(INIT_CYC + 1);

    localparam logic [CNT_W-1:0] INIT_LAST = CNT_W'(INIT_CYC - 1);
    localparam logic [CNT_W-1:0] TAIL_LAST = CNT_W'(TAIL_CYC - 1);
    localparam logic [CNT_W-1:0] FIN_LAST  = CNT_W'(FIN_CYC - 1);
    localparam logic [CNT_W-1:0] TAG_START = CNT_W'(TAG_FIRST);

    phase_e           ph_q, ph_d;
    logic [CNT_W-1:0] cnt;
    logic             ad_pend, pt_pend;
    logic             run_load;
    logic             in_ad_data, in_pt_data, in_tail, fixed_step;
    logic             ad_take, pt_take;
    logic             done_q;
    msel_e            sel;

    // Phase decode shared by handshakes, step gating and selection.
    always_comb begin
        run_load   = (ph_q == PH_IDLE) && start;
        in_ad_data = (ph_q == PH_AD)  && ad_pend;
        in_pt_data = (ph_q == PH_ENC) && pt_pend;
        in_tail    = ((ph_q == PH_AD)  && !ad_pend) ||
                     ((ph_q == PH_ENC) && !pt_pend);
        ad_take    = in_ad_data && ad_valid;
        pt_take    = in_pt_data && pt_valid;
        fixed_step = (ph_q == PH_INIT) || (ph_q == PH_FIN) || in_tail;
    end

    aead_word_tracker #(.CW(LEN_W)) u_ad_words (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (run_load),
        .load_words (ad_len >> DW_LG),
        .take       (ad_take),
        .pending    (ad_pend)
    );

    aead_word_tracker #(.CW(LEN_W)) u_pt_words (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (run_load),
        .load_words (pt_len >> DW_LG),
        .take       (pt_take),
        .pending    (pt_pend)
    );

    aead_step_timer #(.CW(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (ph_d != ph_q),
        .adv   (fixed_step),
        .cnt   (cnt)
    );

    // Next phase: strict order, each fixed part ends on its last count.
    always_comb begin
        ph_d = ph_q;
        case (ph_q)
            PH_IDLE: if (start)                          ph_d = PH_INIT;
            PH_INIT: if (cnt == INIT_LAST)               ph_d = PH_AD;
            PH_AD:   if (!ad_pend && cnt == TAIL_LAST)   ph_d = PH_ENC;
            PH_ENC:  if (!pt_pend && cnt == TAIL_LAST)   ph_d = PH_FIN;
            PH_FIN:  if (cnt == FIN_LAST)                ph_d = PH_IDLE;
            default:                                     ph_d = PH_IDLE;
        endcase
    end

    // Phase register and the completion pulse after the last tag word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= PH_IDLE;
            done_q <= 1'b0;
        end else begin
            ph_q   <= ph_d;
            done_q <= (ph_q == PH_FIN) && (cnt == FIN_LAST);
        end
    end

    // Message source: data words, one pad word opening each tail, else zero.
    always_comb begin
        if (in_ad_data || in_pt_data) begin
            sel = MS_DATA;
        end else if (in_tail && (cnt == '0)) begin
            sel = MS_PAD;
        end else begin
            sel = MS_ZERO;
        end
    end

    aead_msg_path #(.DW(DW)) u_path (
        .sel      (sel),
        .use_pt   (ph_q == PH_ENC),
        .ad_data  (ad_data),
        .pt_data  (pt_data),
        .ks_word  (ks_word),
        .msg_word (msg_word),
        .ct_word  (ct_word)
    );

    assign phase       = ph_q;
    assign msg_sel     = sel;
    assign step        = fixed_step || ad_take || pt_take;
    assign key_iv_load = (ph_q == PH_INIT);
    assign ad_ready    = in_ad_data;
    assign pt_ready    = in_pt_data;
    assign ct_valid    = pt_take;
    assign tag_valid   = (ph_q == PH_FIN) && (cnt >= TAG_START);
    assign tag_idx     = TAG_IW'(cnt - TAG_START);
    assign tag_word    = ks_word;
    assign done        = done_q;

endmodule

// File: rtl/aead_phase_seq_chk.sv
// Protocol checker for aead_phase_seq, attached by bind.
// Observes ports only; all properties are disabled while reset is held.
module aead_phase_seq_chk
    import aead_seq_pkg::*;
#(
    parameter int DW     = 32,
    parameter int TAG_IW = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        phase,
    input logic              step,
    input logic              key_iv_load,
    input logic [1:0]        msg_sel,
    input logic [DW-1:0]     msg_word,
    input logic              ad_valid,
    input logic              ad_ready,
    input logic              pt_valid,
    input logic              pt_ready,
    input logic              ct_valid,
    input logic              tag_valid,
    input logic [TAG_IW-1:0] tag_idx,
    input logic              done
);

    // R2: key/IV phase steps the core and loads key material every cycle
    assert_init_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_INIT) |-> (key_iv_load && step && msg_sel == MS_ZERO));

    // R3: a missing associated-data word stalls the core
    assert_ad_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_ready && !ad_valid) |-> !step);

    // R3: both data handshakes are never open together
    assert_ready_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(ad_ready && pt_ready));

    // R5: ciphertext only appears for an offered plaintext word in encryption
    assert_ct_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ct_valid |-> (phase == PH_ENC && pt_valid && pt_ready));

    // R7: finalization feeds zero message words
    assert_fin_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FIN) |-> (msg_sel == MS_ZERO && msg_word == '0 && step));

    // R8: tag words only in finalization, indices consecutive
    assert_tag_in_fin_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tag_valid |-> (phase == PH_FIN));

    assert_tag_seq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_valid && $past(tag_valid)) |-> (tag_idx == TAG_IW'($past(tag_idx) + 1'b1)));

    // R9: done is a single-cycle pulse straight after finalization
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_fin_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (phase == PH_IDLE && $past(phase) == PH_FIN));

    // R10: phases advance only forward, wrapping from finalization to idle
    assert_phase_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != $past(phase)) |->
            ((phase == 3'($past(phase) + 3'd1)) ||
             ($past(phase) == PH_FIN && phase == PH_IDLE)));

    // R1: idle drives no strobes
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> !(step || key_iv_load || ad_ready || pt_ready || tag_valid));

endmodule

bind aead_phase_seq aead_phase_seq_chk #(.DW(DW), .TAG_IW(TAG_IW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase       (phase),
    .step        (step),
    .key_iv_load (key_iv_load),
    .msg_sel     (msg_sel),
    .msg_word    (msg_word),
    .ad_valid    (ad_valid),
    .ad_ready    (ad_ready),
    .pt_valid    (pt_valid),
    .pt_ready    (pt_ready),
    .ct_valid    (ct_valid),
    .tag_valid   (tag_valid),
    .tag_idx     (tag_idx),
    .done        (done)
);

// File: tb/tb_aead_phase_seq.sv
// Sweep bench: every 0..3-word combination for both data phases, with and
// without stalls, chained runs that start in the done cycle, plus two runs of
// an 8-bit-datapath instance timed per phase.
module tb_aead_phase_seq;

    localparam int CLK_PERIOD = 10;
    localparam int INIT32 = 56, TAIL32 = 8, FIN32 = 24, TAGW32 = 4;
    localparam int INIT8 = 224, TAIL8 = 32, FIN8 = 96, TAGW8 = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] ad_len = '0, pt_len = '0;
    logic        ad_valid = 1'b0, pt_valid = 1'b0;
    logic [31:0] ad_data = '0, pt_data = '0, ks_word = '0;
    logic        ad_ready, pt_ready, step, key_iv_load, ct_valid, tag_valid, done;
    logic [2:0]  phase;
    logic [1:0]  msg_sel;
    logic [31:0] msg_word, ct_word, tag_word;
    logic [1:0]  tag_idx;

    logic        s8_start = 1'b0;
    logic [15:0] s8_ad_len = '0, s8_pt_len = '0;
    logic        d8_ad_ready, d8_pt_ready, d8_step, d8_kl, d8_ct_valid, d8_tag_valid, d8_done;
    logic [2:0]  d8_phase;
    logic [1:0]  d8_msg_sel;
    logic [7:0]  d8_msg_word, d8_ct_word, d8_tag_word;
    logic [3:0]  d8_tag_idx;

    int checks = 0;
    int errors = 0;
    int unsigned cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    aead_phase_seq #(.DW(32), .LEN_W(16)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ad_len(ad_len), .pt_len(pt_len),
        .ad_valid(ad_valid), .ad_data(ad_data), .ad_ready(ad_ready),
        .pt_valid(pt_valid), .pt_data(pt_data), .pt_ready(pt_ready),
        .ks_word(ks_word), .phase(phase), .step(step), .key_iv_load(key_iv_load),
        .msg_sel(msg_sel), .msg_word(msg_word), .ct_valid(ct_valid), .ct_word(ct_word),
        .tag_valid(tag_valid), .tag_idx(tag_idx), .tag_word(tag_word), .done(done)
    );

    aead_phase_seq #(.DW(8), .LEN_W(16)) dut8 (
        .clk(clk), .rst_n(rst_n), .start(s8_start), .ad_len(s8_ad_len), .pt_len(s8_pt_len),
        .ad_valid(1'b1), .ad_data(8'h00), .ad_ready(d8_ad_ready),
        .pt_valid(1'b1), .pt_data(8'h00), .pt_ready(d8_pt_ready),
        .ks_word(8'h00), .phase(d8_phase), .step(d8_step), .key_iv_load(d8_kl),
        .msg_sel(d8_msg_sel), .msg_word(d8_msg_word), .ct_valid(d8_ct_valid), .ct_word(d8_ct_word),
        .tag_valid(d8_tag_valid), .tag_idx(d8_tag_idx), .tag_word(d8_tag_word), .done(d8_done)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: act=%0h exp=%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic new_ks();
        cyc++;
        ks_word = 32'h9E3779B9 * cyc;
    endtask

    // One DW=32 run; chain_next raises start in the done cycle for the next run.
    task automatic run32(input int adw, input int ptw, input bit stall,
                         input bit chained, input bit chain_next,
                         input int nad, input int npt);
        int acc;
        int guard;
        if (!chained) begin
            @(negedge clk);
            start = 1'b1;
            ad_len = 16'(adw * 32);
            pt_len = 16'(ptw * 32);
        end
        // R2: key/IV phase
        for (int i = 0; i < INIT32; i++) begin
            @(negedge clk);
            start = 1'b0;
            new_ks();
            #1;
            chk(phase == 3'd1 && key_iv_load && step && msg_sel == 2'd2 && !ad_ready && !pt_ready,
                "R2 init", phase, 1);
            if (i == 0) chk(!done, "R9 done low on restart", done, 0);
        end
        // R3: associated-data words, optional stalls, start held (R9 ignored)
        acc = 0;
        guard = 0;
        while (acc < adw && guard < 64) begin
            @(negedge clk);
            new_ks();
            ad_valid = stall ? cyc[0] : 1'b1;
            ad_data = 32'hA0D0_0000 + cyc;
            start = stall;
            #1;
            chk(phase == 3'd2 && ad_ready && step == ad_valid && msg_sel == 2'd0 && msg_word == ad_data,
                "R3 ad word", {phase, ad_ready, step, msg_sel}, {3'd2, 1'b1, ad_valid, 2'd0});
            if (ad_valid) acc++;
            guard++;
        end
        // R4: associated-data tail
        for (int t = 0; t < TAIL32; t++) begin
            @(negedge clk);
            new_ks();
            ad_valid = 1'b1;
            start = 1'b0;
            #1;
            chk(phase == 3'd2 && !ad_ready && step &&
                msg_sel == (t == 0 ? 2'd1 : 2'd2) && msg_word == (t == 0 ? 32'd1 : 32'd0),
                "R4 ad tail", {phase, msg_sel, msg_word}, {3'd2, (t == 0 ? 2'd1 : 2'd2), (t == 0 ? 32'd1 : 32'd0)});
        end
        ad_valid = 1'b0;
        // R5: plaintext words and ciphertext
        acc = 0;
        guard = 0;
        while (acc < ptw && guard < 64) begin
            @(negedge clk);
            new_ks();
            pt_valid = stall ? ~cyc[0] : 1'b1;
            pt_data = 32'h5EED_0000 ^ (cyc * 7);
            #1;
            chk(phase == 3'd3 && pt_ready && step == pt_valid && msg_sel == 2'd0 && msg_word == pt_data,
                "R5 pt word", {phase, pt_ready, step}, {3'd3, 1'b1, pt_valid});
            chk(ct_valid == pt_valid && (!pt_valid || ct_word == (pt_data ^ ks_word)),
                "R5 ciphertext", ct_word, pt_data ^ ks_word);
            if (pt_valid) acc++;
            guard++;
        end
        // R6: encryption tail, no ciphertext
        for (int t = 0; t < TAIL32; t++) begin
            @(negedge clk);
            new_ks();
            pt_valid = 1'b1;
            #1;
            chk(phase == 3'd3 && !pt_ready && !ct_valid && step &&
                msg_sel == (t == 0 ? 2'd1 : 2'd2) && msg_word == (t == 0 ? 32'd1 : 32'd0),
                "R6 pt tail", {phase, ct_valid, msg_sel}, {3'd3, 1'b0, (t == 0 ? 2'd1 : 2'd2)});
        end
        pt_valid = 1'b0;
        // R7/R8: finalization and tag words
        for (int f = 0; f < FIN32; f++) begin
            @(negedge clk);
            new_ks();
            #1;
            chk(phase == 3'd4 && step && msg_sel == 2'd2 && msg_word == 32'd0 && !ct_valid,
                "R7 finalize", {phase, msg_sel}, {3'd4, 2'd2});
            chk(tag_valid == (f >= FIN32 - TAGW32) &&
                (!tag_valid || (tag_idx == 2'(f - (FIN32 - TAGW32)) && tag_word == ks_word)),
                "R8 tag", {tag_valid, tag_idx}, {(f >= FIN32 - TAGW32), 2'(f - (FIN32 - TAGW32))});
        end
        // R9: done pulse, possibly overlapping the next start
        @(negedge clk);
        start = chain_next;
        ad_len = 16'(nad * 32);
        pt_len = 16'(npt * 32);
        #1;
        chk(done && phase == 3'd0 && !tag_valid, "R9 done", {done, phase}, {1'b1, 3'd0});
        if (!chain_next) begin
            @(negedge clk);
            #1;
            chk(!done && phase == 3'd0 && !step, "R9 done single", {done, phase}, {1'b0, 3'd0});
        end
    endtask

    // R2/R4/R6/R7/R8 at DW=8: per-phase cycle counts with words always valid.
    task automatic run8(input int adb, input int ptb);
        int n_init, n_ad, n_enc, n_fin, n_ct, n_tag, n_pad;
        n_init = 0; n_ad = 0; n_enc = 0; n_fin = 0; n_ct = 0; n_tag = 0; n_pad = 0;
        @(negedge clk);
        s8_start = 1'b1;
        s8_ad_len = 16'(adb * 8);
        s8_pt_len = 16'(ptb * 8);
        @(negedge clk);
        s8_start = 1'b0;
        for (int k = 0; k < 2000; k++) begin
            #1;
            if (d8_done) break;
            case (d8_phase)
                3'd1: n_init++;
                3'd2: n_ad++;
                3'd3: n_enc++;
                3'd4: n_fin++;
                default: ;
            endcase
            if (d8_ct_valid) n_ct++;
            if (d8_tag_valid) n_tag++;
            if (d8_msg_sel == 2'd1) n_pad++;
            @(negedge clk);
        end
        chk(d8_done && d8_phase == 3'd0, "R9 dw8 done", d8_done, 1);
        chk(n_init == INIT8, "R2 dw8 init length", n_init, INIT8);
        chk(n_ad == adb + TAIL8, "R4 dw8 ad length", n_ad, adb + TAIL8);
        chk(n_enc == ptb + TAIL8, "R6 dw8 enc length", n_enc, ptb + TAIL8);
        chk(n_fin == FIN8, "R7 dw8 fin length", n_fin, FIN8);
        chk(n_tag == TAGW8, "R8 dw8 tag words", n_tag, TAGW8);
        chk(n_ct == ptb, "R5 dw8 ciphertext words", n_ct, ptb);
        chk(n_pad == 2, "R4 dw8 pad words", n_pad, 2);
    endtask

    initial begin : main
        bit chain_in;
        repeat (3) @(negedge clk);
        #1;
        // R1: outputs while reset is held
        chk(phase == 3'd0 && !done && !step && !key_iv_load && !ad_ready && !pt_ready &&
            !ct_valid && !tag_valid, "R1 in reset", phase, 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(phase == 3'd0 && !done && !step && !key_iv_load && !ad_ready && !pt_ready &&
            !ct_valid && !tag_valid, "R1 after reset", phase, 0);

        chain_in = 1'b0;
        for (int n = 0; n < 32; n++) begin
            int s, a, p, na, np;
            bit cn;
            s = n / 16;
            a = (n / 4) % 4;
            p = n % 4;
            na = ((n + 1) / 4) % 4;
            np = (n + 1) % 4;
            cn = (n % 3 == 0) && (n < 31);
            run32(a, p, s[0], chain_in, cn, na, np);
            chain_in = cn;
        end

        run8(0, 0);
        run8(3, 5);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: act=%0d exp=%0d", 200000, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule